// File: doc/BRIEF.md
# Dual-Channel Converter Code Latch Controller

This block is the digital front end for two identical digital-to-analog converter channels. Software writes each channel's configuration word and data word through a simple register write port. The block turns each data word into a 12-bit unsigned converter code. It handles 8-bit or 12-bit resolution, unsigned or two's complement input, and left or right alignment inside the 16-bit word.

The block also decides when a converter's output latch takes a new code. A channel can load on every data write. It can load on a data write only while conversion is enabled. Its channels can be grouped so that they update together once every grouped channel has received new data. A channel can also wait for a rising edge on one of two external timer strobes. Those strobes are asynchronous and are synchronized inside the block. The converter latches are the only outputs.

Top module: `dac_latch_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every channel's output code is 000h until a load takes place, and all configuration and data registers read as zero.
- R2: Register map. wr_addr bit 0 selects the data word (1) or the configuration word (0), and wr_addr bit 1 selects channel 0 or 1. The configuration word fields are as follows. Bit 0 enables conversion. Bit 1 groups the channels and has effect only in channel 0's word. Bit 2 selects two's complement (1) or unsigned (0) input. Bit 3 selects left (1) or right (0) alignment. Bit 4 selects 8-bit (1) or 12-bit (0) resolution. Bits 11:10 select the load trigger. A register write takes effect at the clock edge where wr_en is sampled high.
- R3: In 12-bit resolution with unsigned right alignment, the code equals data bits 11:0.
- R4: With left alignment, the active field is data bits 15:4 in 12-bit resolution and data bits 15:8 in 8-bit resolution. With right alignment, it is bits 11:0 or bits 7:0.
- R5: In 8-bit resolution, the 8-bit value fills code bits 11:4, and code bits 3:0 are zero.
- R6: In two's complement input, the top bit of the active field is inverted. In 12-bit mode 800h gives code 000h and 7FFh gives FFFh. In 8-bit mode 80h gives 000h and 7Fh gives FF0h.
- R7: With trigger 00, the latch takes the formatted data at the clock edge after the one that wrote the data word, whatever the value of the enable bit.
- R8: With trigger 01 on an ungrouped channel, a data write loads the latch with the same timing as R7, but only while the enable bit is 1. A write made with the enable bit at 0 leaves the output unchanged.
- R9: When the channels are grouped, an enabled channel with trigger 01 loads only after both data words have been written since the last group load. The enabled channels then load at the same edge, one edge after the second write. The written record is then cleared, so a following single write loads nothing.
- R10: With trigger 10 (strobe A) or 11 (strobe B) and the enable bit at 1, a low-to-high transition of the selected strobe loads the latch at the third clock edge after the strobe is first sampled high. A strobe held high does not load again.
- R11: With a strobe trigger, the strobe that is not selected has no effect on the latch. Neither strobe has any effect while the enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: bit 1 channel, bit 0 data/config |
| wr_data | input | 16 | Register write value |
| strobe_a | input | 1 | Asynchronous timer strobe A |
| strobe_b | input | 1 | Asynchronous timer strobe B |
| dac_code | output | 24 | Latched converter codes, channel n at bits 12n+11:12n |

## Verification
The assertions assume that each register write lasts one cycle, and that a grouped load is never in the same cycle as a new data write. Otherwise the written record carries the new write forward, and the load-clear check does not hold for that cycle. The bench drives every write for exactly one clock and gives each load time to finish before the next write. Strobes are held high for several cycles, so the synchronizer sees each transition once. The bench changes configuration only between loads, so a formatted code is never taken in the cycle its format changes.

// File: rtl/dac_latch_pkg.sv
package dac_latch_pkg;

  typedef enum logic [1:0] {
    LD_WRITE  = 2'b00,
    LD_GROUP  = 2'b01,
    LD_STRB_A = 2'b10,
    LD_STRB_B = 2'b11
  } load_sel_e;

  typedef struct packed {
    load_sel_e load_sel;
    logic      res8;
    logic      just_left;
    logic      twos;
    logic      group;
    logic      enc;
  } chan_cfg_t;

  function automatic chan_cfg_t decode_ctrl(input logic [15:0] w);
    chan_cfg_t c;
    c.enc       = w[0];
    c.group     = w[1];
    c.twos      = w[2];
    c.just_left = w[3];
    c.res8      = w[4];
    c.load_sel  = load_sel_e'(w[11:10]);
    return c;
  endfunction

endpackage

// File: rtl/dac_strobe_sync.sv
module dac_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);

  logic [STAGES-1:0] sync_d, sync_q;
  logic              prev_d, prev_q;

  generate
    if (STAGES > 1) begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], async_in};
    end else begin : g_single
      always_comb sync_d = async_in;
    end
  endgenerate

  always_comb begin
    prev_d = sync_q[STAGES-1];
    rise_o = sync_q[STAGES-1] & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // R10
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/dac_code_format.sv
module dac_code_format #(
  parameter int CODE_W   = 12,
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              res8_i,
  input  logic              twos_i,
  input  logic              left_i,
  output logic [CODE_W-1:0] code_o
);

  localparam int PAD_W = CODE_W - NARROW_W;

  logic [CODE_W-1:0]   wide;
  logic [NARROW_W-1:0] narrow;

  always_comb begin
    wide   = left_i ? data_i[DATA_W-1 -: CODE_W]   : data_i[CODE_W-1:0];
    narrow = left_i ? data_i[DATA_W-1 -: NARROW_W] : data_i[NARROW_W-1:0];
    if (twos_i) begin
      wide[CODE_W-1]     = ~wide[CODE_W-1];
      narrow[NARROW_W-1] = ~narrow[NARROW_W-1];
    end
    code_o = res8_i ? {narrow, {PAD_W{1'b0}}} : wide;
  end

endmodule

// File: rtl/dac_group_track.sv
module dac_group_track #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           grouped_i,
  input  logic [NCH-1:0] data_we_i,
  output logic           grp_load_o
);

  logic [NCH-1:0] seen_d, seen_q;

  always_comb begin
    grp_load_o = grouped_i & (&seen_q);
    if (!grouped_i) begin
      seen_d = '0;
    end else begin
      seen_d = data_we_i | (seen_q & {NCH{~grp_load_o}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= seen_d;
  end

  // R9
  group_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_load_o && !(|data_we_i)) |=> (seen_q == '0));

endmodule

// File: rtl/dac_latch_chan.sv
module dac_latch_chan
  import dac_latch_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              grouped_i,
  input  logic              grp_load_i,
  input  logic              strb_a_rise_i,
  input  logic              strb_b_rise_i,
  output chan_cfg_t         cfg_o,
  output logic [CODE_W-1:0] code_o
);

  localparam int PAD_W = CODE_W - NARROW_W;

  chan_cfg_t         cfg_d, cfg_q;
  logic [DATA_W-1:0] data_d, data_q;
  logic              wseen_d, wseen_q;
  logic [CODE_W-1:0] latch_d, latch_q;
  logic [CODE_W-1:0] fmt_code;
  logic              load;

  dac_code_format #(
    .CODE_W  (CODE_W),
    .DATA_W  (DATA_W),
    .NARROW_W(NARROW_W)
  ) u_fmt (
    .data_i (data_q),
    .res8_i (cfg_q.res8),
    .twos_i (cfg_q.twos),
    .left_i (cfg_q.just_left),
    .code_o (fmt_code)
  );

  always_comb begin
    unique case (cfg_q.load_sel)
      LD_WRITE:  load = wseen_q;
      LD_GROUP:  load = cfg_q.enc & (grouped_i ? grp_load_i : wseen_q);
      LD_STRB_A: load = cfg_q.enc & strb_a_rise_i;
      LD_STRB_B: load = cfg_q.enc & strb_b_rise_i;
      default:   load = 1'b0;
    endcase
  end

  always_comb begin
    cfg_d   = ctrl_we_i ? decode_ctrl(wr_data_i) : cfg_q;
    data_d  = data_we_i ? wr_data_i : data_q;
    wseen_d = data_we_i;
    latch_d = load ? fmt_code : latch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      data_q  <= '0;
      wseen_q <= 1'b0;
      latch_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      data_q  <= data_d;
      wseen_q <= wseen_d;
      latch_q <= latch_d;
    end
  end

  assign cfg_o  = cfg_q;
  assign code_o = latch_q;

  // R7
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.load_sel == LD_WRITE && wseen_q) |=> (latch_q == $past(fmt_code)));

  // R11
  enc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.enc && cfg_q.load_sel != LD_WRITE) |=> $stable(latch_q));

  // R9
  group_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grouped_i && cfg_q.load_sel == LD_GROUP && !grp_load_i) |=> $stable(latch_q));

  // R5
  narrow_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cfg_q.res8) |=> (latch_q[PAD_W-1:0] == '0));

endmodule

// File: rtl/dac_latch_ctrl.sv
module dac_latch_ctrl
  import dac_latch_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int CODE_W      = 12,
  parameter int DATA_W      = 16,
  parameter int NARROW_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NCH):0]    wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    strobe_a,
  input  logic                    strobe_b,
  output logic [NCH*CODE_W-1:0]   dac_code
);

  localparam int CH_AW = $clog2(NCH);

  logic             rise_a, rise_b;
  logic             grp_load;
  logic             grouped;
  logic [NCH-1:0]   ctrl_we, data_we;
  chan_cfg_t        cfg [NCH];

  dac_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst_n(rst_n), .async_in(strobe_a), .rise_o(rise_a));

  dac_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst_n(rst_n), .async_in(strobe_b), .rise_o(rise_b));

  always_comb grouped = cfg[0].group;

  dac_group_track #(.NCH(NCH)) u_group (
    .clk       (clk),
    .rst_n     (rst_n),
    .grouped_i (grouped),
    .data_we_i (data_we),
    .grp_load_o(grp_load)
  );

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      always_comb begin
        ctrl_we[ch] = wr_en && (wr_addr[CH_AW:1] == CH_AW'(ch)) && !wr_addr[0];
        data_we[ch] = wr_en && (wr_addr[CH_AW:1] == CH_AW'(ch)) &&  wr_addr[0];
      end

      dac_latch_chan #(
        .CODE_W  (CODE_W),
        .DATA_W  (DATA_W),
        .NARROW_W(NARROW_W)
      ) u_chan (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_we_i    (ctrl_we[ch]),
        .data_we_i    (data_we[ch]),
        .wr_data_i    (wr_data),
        .grouped_i    (grouped),
        .grp_load_i   (grp_load),
        .strb_a_rise_i(rise_a),
        .strb_b_rise_i(rise_b),
        .cfg_o        (cfg[ch]),
        .code_o       (dac_code[ch*CODE_W +: CODE_W])
      );
    end
  endgenerate

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_we, data_we}));

endmodule

// File: tb/dac_latch_ctrl_tb.sv
`timescale 1ns/1ps
module dac_latch_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic        strobe_a, strobe_b;
  logic [23:0] dac_code;

  always #2.5 clk = ~clk;

  dac_latch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .dac_code(dac_code));

  typedef struct {
    int         due;
    int         ch;
    logic [11:0] exp;
    string      req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items when due and compares
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      logic [11:0] act;
      e = q.pop_front();
      act = dac_code[e.ch*12 +: 12];
      checks++;
      if (act !== e.exp) begin
        errors++;
        $display("FAIL %s ch%0d: actual %03h expected %03h", e.req, e.ch, act, e.exp);
      end
    end
  end

  task automatic expect_code(input int ch, input logic [11:0] v, input int dly, input string req);
    exp_t e;
    e.due = cyc + dly; e.ch = ch; e.exp = v; e.req = req;
    q.push_back(e);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain();
    repeat (5) @(negedge clk);
  endtask

  // write data to channel 0 and expect the code one edge later
  task automatic data0(input logic [15:0] d, input logic [11:0] v, input string req);
    wr(2'd1, d);
    expect_code(0, v, 1, req);
    drain();
  endtask

  task automatic pulse(input bit which_b);
    if (which_b) strobe_b = 1'b1; else strobe_a = 1'b1;
  endtask

  task automatic release_strobes();
    repeat (4) @(negedge clk);
    strobe_a = 1'b0; strobe_b = 1'b0;
    drain();
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    strobe_a = 1'b0; strobe_b = 1'b0;
    repeat (3) @(negedge clk);
    expect_code(0, 12'h000, 0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_code(0, 12'h000, 0, "R1 after reset");
    expect_code(1, 12'h000, 0, "R1 after reset");
    @(negedge clk);

    // trigger 00, enable 0 still loads
    wr(2'd0, 16'h0000);
    data0(16'h0ABC, 12'hABC, "R3 R7 unsigned right 12-bit");
    wr(2'd0, 16'h0008);
    data0(16'hABCD, 12'hABC, "R4 left 12-bit");
    wr(2'd0, 16'h0010);
    data0(16'h12A5, 12'hA50, "R5 right 8-bit");
    wr(2'd0, 16'h0018);
    data0(16'hA512, 12'hA50, "R4 left 8-bit");
    wr(2'd0, 16'h0004);
    data0(16'h0800, 12'h000, "R6 twos 12-bit min");
    data0(16'h07FF, 12'hFFF, "R6 twos 12-bit max");
    wr(2'd0, 16'h0014);
    data0(16'h0080, 12'h000, "R6 twos 8-bit min");
    data0(16'h007F, 12'hFF0, "R6 twos 8-bit max");

    // R8: trigger 01, not grouped
    wr(2'd2, 16'h0400);
    wr(2'd3, 16'h0123);
    expect_code(1, 12'h000, 1, "R8 enable low ignored");
    expect_code(1, 12'h000, 3, "R8 enable low ignored");
    drain();
    wr(2'd2, 16'h0401);
    wr(2'd3, 16'h0456);
    expect_code(1, 12'h456, 1, "R8 enabled load");
    drain();

    // R9: grouped
    wr(2'd0, 16'h0403);
    wr(2'd1, 16'h0111);
    expect_code(0, 12'hFF0, 1, "R9 waits for partner");
    expect_code(0, 12'hFF0, 3, "R9 waits for partner");
    drain();
    wr(2'd3, 16'h0222);
    expect_code(0, 12'h111, 1, "R9 group load ch0");
    expect_code(1, 12'h222, 1, "R9 group load ch1");
    drain();
    wr(2'd1, 16'h0333);
    expect_code(0, 12'h111, 3, "R9 record cleared");
    drain();

    // R10/R11: strobes
    wr(2'd0, 16'h0801);
    wr(2'd1, 16'h0555);
    expect_code(0, 12'h111, 2, "R10 no load on write");
    drain();
    pulse(1'b1);
    expect_code(0, 12'h111, 4, "R11 other strobe ignored");
    release_strobes();
    pulse(1'b0);
    expect_code(0, 12'h111, 2, "R10 not yet loaded");
    expect_code(0, 12'h555, 3, "R10 strobe A load");
    release_strobes();

    wr(2'd2, 16'h0C00);
    wr(2'd3, 16'h0777);
    drain();
    pulse(1'b1);
    expect_code(1, 12'h222, 4, "R11 enable low strobe ignored");
    release_strobes();
    wr(2'd2, 16'h0C01);
    pulse(1'b1);
    expect_code(1, 12'h777, 3, "R10 strobe B load");
    repeat (5) @(negedge clk);
    wr(2'd3, 16'h0999);
    expect_code(1, 12'h777, 4, "R10 held strobe no reload");
    release_strobes();

    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule